// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block decides, for each load entering the out-of-order window, whether it may issue as soon as its address operands are ready, whether it must wait behind one particular older in-flight store, or whether it must be held behind all older stores. It keeps two tables. The first, indexed by instruction address mixed with recent branch outcomes, assigns loads and stores a store-set number. The second, indexed by that number, remembers the reorder-buffer tag of the youngest in-flight store of each set.

Memory-order violations train the first table so that the offending load and store share one set. Later instances of that load are then told to wait for that store. A per-entry 2-bit confidence counter holds back predictions for loads whose aliasing history is not yet trusted. Store resolution, pipeline flushes and a bulk-clear pulse keep the tables from going stale. One decision leaves the block per dispatched load, registered one cycle after dispatch.

Top module: `mdp_store_set`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid_o` is 0 and `hist_o` is 0.
- R2: The table index is `pc[13:2] XOR hist`, where hist is the 12-bit outcome history. Each cycle with `br_valid_i` high shifts `br_taken_i` into bit 0 and moves the older bits up by one.
- R3: Each entry has a 2-bit confidence value that starts at 0, saturates at 3, increments on `ldok_valid_i` and returns to 0 when the entry is the load side of a violation. A load whose entry holds a value below 2 gets `res_hold_o`=1 and `res_wait_o`=0.
- R4: A trusted load whose entry holds no store-set number gets `res_hold_o`=0, `res_wait_o`=0 and `res_tag_o`=0.
- R5: A trusted load whose set has a live store entry gets `res_wait_o`=1, with `res_tag_o` equal to that store's tag.
- R6: A dispatched store with a valid set number records its tag as the set's live store. Only loads produce a decision, one cycle after dispatch.
- R7: A store resolve clears only the set entries whose recorded tag equals the resolving tag.
- R8: `flush_i` invalidates every live-store entry, overriding a store write in the same cycle, and suppresses the decision of a load dispatched in that cycle.
- R9: A violation where neither side has a set number gives both the low 8 bits of the load's index.
- R10: A violation where only one side has a set number gives that number to the other side.
- R11: A violation where both sides have set numbers gives both the smaller number.
- R12: `clr_i` invalidates every set number in one cycle and blocks set-number writes from training in the same cycle.
- R13: `res_tag_o` is 0 whenever `res_wait_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch lookup valid |
| disp_is_store_i | input | 1 | 1 = store, 0 = load |
| disp_pc_i | input | 32 | Dispatched instruction address |
| disp_tag_i | input | 7 | Reorder-buffer tag of dispatched op |
| br_valid_i | input | 1 | A conditional branch resolved |
| br_taken_i | input | 1 | Its outcome |
| hist_o | output | 12 | Current branch history, snapshotted with each op |
| rsv_valid_i | input | 1 | A store resolved |
| rsv_tag_i | input | 7 | Tag of the resolving store |
| viol_valid_i | input | 1 | Memory-order violation training |
| viol_ld_pc_i | input | 32 | Violating load address |
| viol_ld_hist_i | input | 12 | History snapshot of that load |
| viol_st_pc_i | input | 32 | Violated store address |
| viol_st_hist_i | input | 12 | History snapshot of that store |
| ldok_valid_i | input | 1 | A load completed without conflict |
| ldok_pc_i | input | 32 | Its address |
| ldok_hist_i | input | 12 | Its history snapshot |
| flush_i | input | 1 | Pipeline flush |
| clr_i | input | 1 | Bulk clear of set numbers |
| res_valid_o | output | 1 | Load decision valid |
| res_wait_o | output | 1 | Wait for one store |
| res_hold_o | output | 1 | Hold behind all older stores |
| res_tag_o | output | 7 | Tag of the store to wait on |

## Verification
On every cycle the assertions check that a decision never asks for both wait and hold, that the tag stays zero without a wait, and that decisions appear only after unflushed load dispatches. They also check that flush and clear empty their tables on the next cycle and that the history shifts exactly as the branch inputs say. The training rules (allocate, adopt, smaller-wins), tag-matched resolution, confidence gating and history-dependent indexing show up only in the end-to-end scenarios. In those, a sequence of violations, completions and dispatches must lead to a specific wait tag or to a free or held load.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  localparam int unsigned PC_W    = 32;
  localparam int unsigned IDX_W   = 12;
  localparam int unsigned SSID_W  = 8;
  localparam int unsigned TAG_W   = 7;
  localparam int unsigned CONF_W  = 2;
  localparam int unsigned CONF_TH = 2;
endpackage

// File: rtl/mdp_hist.sv
module mdp_hist #(
  parameter int unsigned W = mdp_pkg::IDX_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         br_valid_i,
  input  logic         br_taken_i,
  output logic [W-1:0] hist_o
);
  logic [W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (br_valid_i) hist_q <= {hist_q[W-2:0], br_taken_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/mdp_ssit.sv
module mdp_ssit #(
  parameter int unsigned IDX_W  = mdp_pkg::IDX_W,
  parameter int unsigned SSID_W = mdp_pkg::SSID_W,
  parameter int unsigned CONF_W = mdp_pkg::CONF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_vld_o,
  output logic [SSID_W-1:0] rd_id_o,
  output logic [CONF_W-1:0] rd_conf_o,
  input  logic              tr_valid_i,
  input  logic [IDX_W-1:0]  tr_ld_idx_i,
  input  logic [IDX_W-1:0]  tr_st_idx_i,
  input  logic              ok_valid_i,
  input  logic [IDX_W-1:0]  ok_idx_i,
  output logic              any_vld_o
);
  localparam int unsigned N = 1 << IDX_W;

  logic [N-1:0]      vld_q;
  logic [SSID_W-1:0] id_q   [N];
  logic [CONF_W-1:0] conf_q [N];

  logic              l_v, s_v;
  logic [SSID_W-1:0] l_id, s_id, new_id;

  assign rd_vld_o  = vld_q[rd_idx_i];
  assign rd_id_o   = id_q[rd_idx_i];
  assign rd_conf_o = conf_q[rd_idx_i];
  assign any_vld_o = |vld_q;

  assign l_v  = vld_q[tr_ld_idx_i];
  assign s_v  = vld_q[tr_st_idx_i];
  assign l_id = id_q[tr_ld_idx_i];
  assign s_id = id_q[tr_st_idx_i];

  // merge rule: allocate, adopt, or smaller wins
  always_comb begin
    if (!l_v && !s_v)     new_id = tr_ld_idx_i[SSID_W-1:0];
    else if (l_v && !s_v) new_id = l_id;
    else if (!l_v)        new_id = s_id;
    else                  new_id = (l_id < s_id) ? l_id : s_id;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (tr_valid_i) begin
      vld_q[tr_ld_idx_i] <= 1'b1;
      vld_q[tr_st_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (tr_valid_i && !clr_i) begin
      id_q[tr_ld_idx_i] <= new_id;
      id_q[tr_st_idx_i] <= new_id;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) conf_q[i] <= '0;
    end else begin
      if (ok_valid_i && conf_q[ok_idx_i] != '1)
        conf_q[ok_idx_i] <= conf_q[ok_idx_i] + CONF_W'(1);
      if (tr_valid_i)
        conf_q[tr_ld_idx_i] <= '0;  // violation overrides same-cycle increment
    end
  end
endmodule

// File: rtl/mdp_lfst.sv
module mdp_lfst #(
  parameter int unsigned SSID_W = mdp_pkg::SSID_W,
  parameter int unsigned TAG_W  = mdp_pkg::TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [SSID_W-1:0] wr_id_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              rsv_valid_i,
  input  logic [TAG_W-1:0]  rsv_tag_i,
  input  logic [SSID_W-1:0] rd_id_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              any_vld_o
);
  localparam int unsigned N = 1 << SSID_W;

  logic [N-1:0]     vld_q;
  logic [TAG_W-1:0] tag_q [N];

  for (genvar g = 0; g < int'(N); g++) begin : g_ent
    logic hit_w;
    assign hit_w = wr_en_i && (wr_id_i == SSID_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  vld_q[g] <= 1'b0;
      else if (flush_i)                             vld_q[g] <= 1'b0;
      else if (hit_w)                               vld_q[g] <= 1'b1;
      else if (rsv_valid_i && tag_q[g] == rsv_tag_i) vld_q[g] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (hit_w) tag_q[g] <= wr_tag_i;
    end
  end

  assign rd_vld_o  = vld_q[rd_id_i];
  assign rd_tag_o  = tag_q[rd_id_i];
  assign any_vld_o = |vld_q;
endmodule

// File: rtl/mdp_store_set.sv
module mdp_store_set #(
  parameter int unsigned PC_W    = mdp_pkg::PC_W,
  parameter int unsigned IDX_W   = mdp_pkg::IDX_W,
  parameter int unsigned SSID_W  = mdp_pkg::SSID_W,
  parameter int unsigned TAG_W   = mdp_pkg::TAG_W,
  parameter int unsigned CONF_W  = mdp_pkg::CONF_W,
  parameter int unsigned CONF_TH = mdp_pkg::CONF_TH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disp_valid_i,
  input  logic             disp_is_store_i,
  input  logic [PC_W-1:0]  disp_pc_i,
  input  logic [TAG_W-1:0] disp_tag_i,
  input  logic             br_valid_i,
  input  logic             br_taken_i,
  output logic [IDX_W-1:0] hist_o,
  input  logic             rsv_valid_i,
  input  logic [TAG_W-1:0] rsv_tag_i,
  input  logic             viol_valid_i,
  input  logic [PC_W-1:0]  viol_ld_pc_i,
  input  logic [IDX_W-1:0] viol_ld_hist_i,
  input  logic [PC_W-1:0]  viol_st_pc_i,
  input  logic [IDX_W-1:0] viol_st_hist_i,
  input  logic             ldok_valid_i,
  input  logic [PC_W-1:0]  ldok_pc_i,
  input  logic [IDX_W-1:0] ldok_hist_i,
  input  logic             flush_i,
  input  logic             clr_i,
  output logic             res_valid_o,
  output logic             res_wait_o,
  output logic             res_hold_o,
  output logic [TAG_W-1:0] res_tag_o
);
  function automatic logic [IDX_W-1:0] idx_f(input logic [PC_W-1:0] pc,
                                             input logic [IDX_W-1:0] h);
    return pc[IDX_W+1:2] ^ h;
  endfunction

  logic [IDX_W-1:0]  disp_idx_w, ld_idx_w, st_idx_w, ok_idx_w;
  logic              id_vld_w, lfst_vld_w, lfst_wr_w;
  logic [SSID_W-1:0] id_w;
  logic [CONF_W-1:0] conf_w;
  logic [TAG_W-1:0]  lfst_tag_w;
  logic              lfst_any_w, ssit_any_w;
  logic              hold_d, wait_d;
  logic              unused_w;

  assign unused_w = ^{disp_pc_i[1:0], disp_pc_i[PC_W-1:IDX_W+2],
                      viol_ld_pc_i[1:0], viol_ld_pc_i[PC_W-1:IDX_W+2],
                      viol_st_pc_i[1:0], viol_st_pc_i[PC_W-1:IDX_W+2],
                      ldok_pc_i[1:0], ldok_pc_i[PC_W-1:IDX_W+2]};

  mdp_hist #(.W(IDX_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .br_valid_i (br_valid_i),
    .br_taken_i (br_taken_i),
    .hist_o     (hist_o)
  );

  assign disp_idx_w = idx_f(disp_pc_i, hist_o);
  assign ld_idx_w   = idx_f(viol_ld_pc_i, viol_ld_hist_i);
  assign st_idx_w   = idx_f(viol_st_pc_i, viol_st_hist_i);
  assign ok_idx_w   = idx_f(ldok_pc_i, ldok_hist_i);

  mdp_ssit #(.IDX_W(IDX_W), .SSID_W(SSID_W), .CONF_W(CONF_W)) u_ssit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .rd_idx_i    (disp_idx_w),
    .rd_vld_o    (id_vld_w),
    .rd_id_o     (id_w),
    .rd_conf_o   (conf_w),
    .tr_valid_i  (viol_valid_i),
    .tr_ld_idx_i (ld_idx_w),
    .tr_st_idx_i (st_idx_w),
    .ok_valid_i  (ldok_valid_i),
    .ok_idx_i    (ok_idx_w),
    .any_vld_o   (ssit_any_w)
  );

  assign lfst_wr_w = disp_valid_i && disp_is_store_i && id_vld_w;

  mdp_lfst #(.SSID_W(SSID_W), .TAG_W(TAG_W)) u_lfst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .wr_en_i     (lfst_wr_w),
    .wr_id_i     (id_w),
    .wr_tag_i    (disp_tag_i),
    .rsv_valid_i (rsv_valid_i),
    .rsv_tag_i   (rsv_tag_i),
    .rd_id_i     (id_w),
    .rd_vld_o    (lfst_vld_w),
    .rd_tag_o    (lfst_tag_w),
    .any_vld_o   (lfst_any_w)
  );

  assign hold_d = conf_w < CONF_W'(CONF_TH);
  assign wait_d = !hold_d && id_vld_w && lfst_vld_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_wait_o  <= 1'b0;
      res_hold_o  <= 1'b0;
      res_tag_o   <= '0;
    end else begin
      res_valid_o <= disp_valid_i && !disp_is_store_i && !flush_i;
      res_wait_o  <= wait_d;
      res_hold_o  <= hold_d;
      res_tag_o   <= wait_d ? lfst_tag_w : '0;
    end
  end
endmodule

// File: rtl/mdp_store_set_chk.sv
module mdp_store_set_chk #(
  parameter int unsigned TAG_W = mdp_pkg::TAG_W,
  parameter int unsigned HW    = mdp_pkg::IDX_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             disp_valid_i,
  input logic             disp_is_store_i,
  input logic             flush_i,
  input logic             clr_i,
  input logic             br_valid_i,
  input logic             br_taken_i,
  input logic [HW-1:0]    hist_o,
  input logic             res_valid_o,
  input logic             res_wait_o,
  input logic             res_hold_o,
  input logic [TAG_W-1:0] res_tag_o,
  input logic             lfst_any_i,
  input logic             ssit_any_i
);
  // R3
  wait_hold_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !(res_wait_o && res_hold_o));

  // R13
  tag_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_wait_o |-> res_tag_o == '0);

  // R6
  res_from_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(disp_valid_i && !disp_is_store_i && !flush_i));

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lfst_any_i);

  // R12
  clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ssit_any_i);

  // R2
  hist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i |=> (hist_o[0] == $past(br_taken_i)) &&
                   (hist_o[HW-1:1] == $past(hist_o[HW-2:0])));

  // R2
  hist_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_valid_i |=> $stable(hist_o));
endmodule

bind mdp_store_set mdp_store_set_chk #(.TAG_W(TAG_W), .HW(IDX_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .disp_valid_i    (disp_valid_i),
  .disp_is_store_i (disp_is_store_i),
  .flush_i         (flush_i),
  .clr_i           (clr_i),
  .br_valid_i      (br_valid_i),
  .br_taken_i      (br_taken_i),
  .hist_o          (hist_o),
  .res_valid_o     (res_valid_o),
  .res_wait_o      (res_wait_o),
  .res_hold_o      (res_hold_o),
  .res_tag_o       (res_tag_o),
  .lfst_any_i      (lfst_any_w),
  .ssit_any_i      (ssit_any_w)
);

// File: tb/tb_mdp_store_set.sv
module tb_mdp_store_set;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        disp_valid_i = 1'b0, disp_is_store_i = 1'b0;
  logic [31:0] disp_pc_i = '0;
  logic [6:0]  disp_tag_i = '0;
  logic        br_valid_i = 1'b0, br_taken_i = 1'b0;
  logic [11:0] hist_o;
  logic        rsv_valid_i = 1'b0;
  logic [6:0]  rsv_tag_i = '0;
  logic        viol_valid_i = 1'b0;
  logic [31:0] viol_ld_pc_i = '0, viol_st_pc_i = '0;
  logic [11:0] viol_ld_hist_i = '0, viol_st_hist_i = '0;
  logic        ldok_valid_i = 1'b0;
  logic [31:0] ldok_pc_i = '0;
  logic [11:0] ldok_hist_i = '0;
  logic        flush_i = 1'b0, clr_i = 1'b0;
  logic        res_valid_o, res_wait_o, res_hold_o;
  logic [6:0]  res_tag_o;

  int total = 0;
  int bad = 0;

  localparam logic [31:0] LA = 32'h40;    // idx 0x010
  localparam logic [31:0] SA = 32'h1000;  // idx 0x400
  localparam logic [31:0] LB = 32'h80;    // idx 0x020
  localparam logic [31:0] SB = 32'h2000;  // idx 0x800
  localparam logic [31:0] LC = 32'h3004;  // idx 0xC01

  always #4 clk_i = ~clk_i;

  mdp_store_set dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic ldok(input logic [31:0] pc, input logic [11:0] h, input int n);
    for (int i = 0; i < n; i++) begin
      ldok_valid_i = 1'b1; ldok_pc_i = pc; ldok_hist_i = h;
      step();
    end
    ldok_valid_i = 1'b0;
  endtask

  task automatic viol(input logic [31:0] lpc, input logic [31:0] spc, input logic with_clr);
    viol_valid_i = 1'b1; viol_ld_pc_i = lpc; viol_st_pc_i = spc;
    viol_ld_hist_i = hist_o; viol_st_hist_i = hist_o; clr_i = with_clr;
    step();
    viol_valid_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic disp_store(input logic [31:0] pc, input logic [6:0] tag);
    disp_valid_i = 1'b1; disp_is_store_i = 1'b1; disp_pc_i = pc; disp_tag_i = tag;
    step();
    disp_valid_i = 1'b0; disp_is_store_i = 1'b0;
    chk("R6 store gives no decision", {31'b0, res_valid_o}, 32'd0);
  endtask

  task automatic disp_load(input string req, input logic [31:0] pc,
                           input logic w, input logic h, input logic [6:0] t);
    disp_valid_i = 1'b1; disp_is_store_i = 1'b0; disp_pc_i = pc; disp_tag_i = 7'h7f;
    step();
    disp_valid_i = 1'b0;
    chk({req, " valid"}, {31'b0, res_valid_o}, 32'd1);
    chk({req, " wait"},  {31'b0, res_wait_o},  {31'b0, w});
    chk({req, " hold"},  {31'b0, res_hold_o},  {31'b0, h});
    chk({req, " tag"},   {25'b0, res_tag_o},   {25'b0, t});
  endtask

  task automatic resolve(input logic [6:0] tag);
    rsv_valid_i = 1'b1; rsv_tag_i = tag;
    step();
    rsv_valid_i = 1'b0;
  endtask

  task automatic flush();
    flush_i = 1'b1;
    step();
    flush_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset valid", {31'b0, res_valid_o}, 32'd0);
    chk("R1 reset hist", {20'b0, hist_o}, 32'd0);
    rst_ni = 1'b1;
    step();
    chk("R1 post-reset valid", {31'b0, res_valid_o}, 32'd0);
  endtask

  task automatic t_cold_and_free();
    disp_load("R3 cold load held", LA, 1'b0, 1'b1, 7'd0);
    ldok(LA, 12'd0, 3);
    disp_load("R4 empty set free", LA, 1'b0, 1'b0, 7'd0);
  endtask

  task automatic t_train_wait();
    viol(LA, SA, 1'b0);                 // R9 alloc 0x10
    disp_store(SA, 7'd5);
    disp_load("R3 conf reset by violation", LA, 1'b0, 1'b1, 7'd0);
    ldok(LA, 12'd0, 2);
    disp_load("R5 R9 wait on store", LA, 1'b1, 1'b0, 7'd5);
  endtask

  task automatic t_resolve();
    resolve(7'd3);
    disp_load("R7 stale tag keeps entry", LA, 1'b1, 1'b0, 7'd5);
    resolve(7'd5);
    disp_load("R7 matching tag clears", LA, 1'b0, 1'b0, 7'd0);
  endtask

  task automatic t_flush();
    disp_store(SA, 7'd6);
    disp_valid_i = 1'b1; disp_is_store_i = 1'b0; disp_pc_i = LA; flush_i = 1'b1;
    step();
    disp_valid_i = 1'b0; flush_i = 1'b0;
    chk("R8 flushed load no decision", {31'b0, res_valid_o}, 32'd0);
    disp_load("R8 flush cleared store", LA, 1'b0, 1'b0, 7'd0);
  endtask

  task automatic t_adopt();
    viol(LC, SA, 1'b0);                 // LC adopts 0x10, not 0x01
    ldok(LC, 12'd0, 2);
    disp_store(SA, 7'd7);
    disp_load("R10 adopted set waits", LC, 1'b1, 1'b0, 7'd7);
    flush();
  endtask

  task automatic t_merge();
    viol(LB, SB, 1'b0);                 // both 0x20
    viol(LA, SB, 1'b0);                 // 0x10 vs 0x20 -> 0x10
    ldok(LA, 12'd0, 2);
    ldok(LB, 12'd0, 2);
    disp_store(SB, 7'd11);
    disp_load("R11 smaller id shared", LA, 1'b1, 1'b0, 7'd11);
    disp_load("R11 other set untouched", LB, 1'b0, 1'b0, 7'd0);
    disp_store(SA, 7'd12);
    disp_load("R6 youngest store recorded", LA, 1'b1, 1'b0, 7'd12);
    flush();
  endtask

  task automatic t_clear();
    disp_store(SA, 7'd14);
    viol(LB, SB, 1'b1);                 // clear wins over training
    ldok(LB, 12'd0, 2);
    disp_load("R12 ids cleared", LA, 1'b0, 1'b0, 7'd0);
    disp_store(SB, 7'd15);
    disp_load("R12 training blocked by clear", LB, 1'b0, 1'b0, 7'd0);
  endtask

  task automatic t_history();
    br_valid_i = 1'b1; br_taken_i = 1'b1;
    step();
    br_valid_i = 1'b0;
    chk("R2 history taken", {20'b0, hist_o}, 32'h1);
    disp_load("R2 new context held", LA, 1'b0, 1'b1, 7'd0);
    br_valid_i = 1'b1; br_taken_i = 1'b0;
    step(); step();
    br_valid_i = 1'b0;
    chk("R2 history shift", {20'b0, hist_o}, 32'h4);
    step();
    chk("R2 history stable", {20'b0, hist_o}, 32'h4);
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    t_cold_and_free();
    t_train_wait();
    t_resolve();
    t_flush();
    t_adopt();
    t_merge();
    t_clear();
    t_history();
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule